// File: doc/BRIEF.md
# Byte-to-Serial Link Transmitter Front End

This block is the transmit side of a 10-bit-coded serial link. It works in one clock domain, the bit clock. A modulo-10 bit counter inside the block marks byte boundaries. A parallel byte and a special-character select are captured at a byte boundary if either of two enables is asserted: one is active high and one is active low. The captured character passes through a 10-bit encoding stage and is then shifted out one bit per clock, least significant bit first. If neither enable is asserted at a boundary, the synchronization character K28.5 goes out in place of data, so the line never goes quiet.

The block also produces an active-low read strobe for an upstream FIFO. While the active-low enable is held low, the strobe sits low for the first six bit periods of each byte and high for the last four. The encoding stage stands in for a full 8b/10b table. It maps data bytes to `{2'b10, byte}` and special bytes to `{2'b11, byte}`, except that a special 0xBC produces the K28.5 code 10'h17C (bit 0 is sent first).

Top module: `serial_tx_front`

## Requirements
- R1: While `rst` is high and on the cycle it is released, `rd_strobe_n` is 1 and `ser_out` carries bit 0 of K28.5 (0). The first character after reset is K28.5 (10'h17C), sent bit by bit from the bit counter's zero.
- R2: After reset, the bit count equals the number of rising edges since release, modulo 10. A byte is captured on each rising edge at which the count was 9 (edges 10, 20, …). It is captured when `tx_en_hi` is 1 or `tx_en_lo_n` is 0 at that edge.
- R3: Values of `tx_data` and `tx_special` at any edge other than a capture edge have no effect on the serial output.
- R4: If `tx_en_hi` is 0 and `tx_en_lo_n` is 1 at a capture edge, the character sent for that byte is K28.5, 10'h17C.
- R5: A captured data byte (`tx_special` 0) is sent as the 10-bit code `{2'b10, tx_data}`.
- R6: A captured special byte (`tx_special` 1) is sent as K28.5 (10'h17C) when `tx_data` is 8'hBC, and otherwise as `{2'b11, tx_data}`.
- R7: A character captured at edge 10m is serialized LSB first. Code bit i is on `ser_out` after edge 10m+10+i, for i = 0..9.
- R8: After edge p, `rd_strobe_n` is 0 exactly when `tx_en_lo_n` was 0 at edge p and p mod 10 is below 6. Otherwise it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, ten per byte |
| rst | input | 1 | Synchronous active-high reset |
| tx_data | input | 8 | Parallel byte to send |
| tx_special | input | 1 | 1 selects a special character |
| tx_en_hi | input | 1 | Active-high capture enable |
| tx_en_lo_n | input | 1 | Active-low capture enable, also gates the strobe |
| ser_out | output | 1 | Serial line output, LSB first |
| rd_strobe_n | output | 1 | Active-low FIFO read strobe, 6 low / 4 high |

## Verification
A bit counter that slips by one cycle moves the byte boundary. Within the next character the serial bits appear rotated against the expected code, and the strobe's low window shifts against the edge count. A capture register that loads off-boundary or keeps a stale valid flag shows up 10 to 20 cycles later as a wrong code, or a missing K28.5, on the line. The bench therefore compares every serial bit and every strobe value on every cycle, while the data inputs are scrambled between boundaries.

// File: rtl/txfe_pkg.sv
package txfe_pkg;
  localparam int DATA_W = 8;
  localparam int CODE_W = DATA_W + 2;
  localparam logic [CODE_W-1:0] K28_5_CODE = 10'h17C;
  localparam logic [DATA_W-1:0] K28_5_BYTE = 8'hBC;

  typedef struct packed {
    logic              valid;
    logic              special;
    logic [DATA_W-1:0] data;
  } txfe_char_t;
endpackage

// File: rtl/txfe_bitcnt.sv
module txfe_bitcnt #(
  parameter int RATIO   = 10,
  parameter int LOW_CNT = 6,
  localparam int CW     = $clog2(RATIO)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_lo_n_i,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o,
  output logic          rd_n_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;
  logic          rd_n_q;

  assign wrap_o  = (cnt_q == CW'(RATIO - 1));
  assign cnt_nxt = wrap_o ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      rd_n_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_nxt;
      rd_n_q <= !(!en_lo_n_i && (cnt_nxt < CW'(LOW_CNT)));
    end
  end

  assign cnt_o  = cnt_q;
  assign rd_n_o = rd_n_q;

  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> (cnt_q == '0)); // R2
  AST_STROBE_LATE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (cnt_q >= CW'(LOW_CNT)) |-> rd_n_q); // R8
endmodule

// File: rtl/txfe_capture.sv
module txfe_capture
  import txfe_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_i,
  input  logic              en_hi_i,
  input  logic              en_lo_n_i,
  input  logic              special_i,
  input  logic [DATA_W-1:0] data_i,
  output txfe_char_t        hold_o
);
  txfe_char_t hold_q;
  logic       take;

  assign take = en_hi_i || !en_lo_n_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
    end else if (cap_i) begin
      hold_q.valid   <= take;
      hold_q.special <= special_i;
      hold_q.data    <= data_i;
    end
  end

  assign hold_o = hold_q;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    !cap_i |=> $stable(hold_q)); // R3
  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (cap_i && !en_hi_i && en_lo_n_i) |=> !hold_q.valid); // R4
endmodule

// File: rtl/txfe_encode.sv
module txfe_encode
  import txfe_pkg::*;
(
  input  txfe_char_t        char_i,
  output logic [CODE_W-1:0] code_o
);
  always_comb begin
    if (!char_i.valid) begin
      code_o = K28_5_CODE;
    end else if (char_i.special) begin
      if (char_i.data == K28_5_BYTE) code_o = K28_5_CODE;
      else                           code_o = {2'b11, char_i.data};
    end else begin
      code_o = {2'b10, char_i.data};
    end
  end
endmodule

// File: rtl/txfe_shifter.sv
module txfe_shifter #(
  parameter int          W        = 10,
  parameter logic [W-1:0] RST_WORD = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] code_i,
  output logic         ser_o
);
  logic [W-1:0] word_q;
  logic         past_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q  <= RST_WORD;
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      if (load_i) word_q <= code_i;
      else        word_q <= {1'b0, word_q[W-1:1]};
    end
  end

  assign ser_o = word_q[0];

  AST_SER_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(load_i)) |-> (ser_o == $past(word_q[1]))); // R7
  AST_SER_LOAD: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(load_i)) |-> (ser_o == $past(code_i[0]))); // R7
endmodule

// File: rtl/serial_tx_front.sv
module serial_tx_front
  import txfe_pkg::*;
#(
  parameter int LOW_CNT = 6,
  localparam int RATIO  = CODE_W,
  localparam int CW     = $clog2(RATIO)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_special,
  input  logic              tx_en_hi,
  input  logic              tx_en_lo_n,
  output logic              ser_out,
  output logic              rd_strobe_n
);
  logic [CW-1:0]     cnt;
  logic              wrap;
  txfe_char_t        hold;
  logic [CODE_W-1:0] code;

  txfe_bitcnt #(.RATIO(RATIO), .LOW_CNT(LOW_CNT)) u_cnt (
    .clk(clk), .rst(rst), .en_lo_n_i(tx_en_lo_n),
    .cnt_o(cnt), .wrap_o(wrap), .rd_n_o(rd_strobe_n)
  );

  txfe_capture u_cap (
    .clk(clk), .rst(rst), .cap_i(wrap),
    .en_hi_i(tx_en_hi), .en_lo_n_i(tx_en_lo_n),
    .special_i(tx_special), .data_i(tx_data), .hold_o(hold)
  );

  txfe_encode u_enc (.char_i(hold), .code_o(code));

  txfe_shifter #(.W(CODE_W), .RST_WORD(K28_5_CODE)) u_shf (
    .clk(clk), .rst(rst), .load_i(wrap), .code_i(code), .ser_o(ser_out)
  );

  AST_STROBE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    !rd_strobe_n |-> $past(!tx_en_lo_n)); // R8
  AST_FILL_ON_IDLE: assert property (@(posedge clk) disable iff (rst)
    (wrap && !hold.valid) |=> (ser_out == K28_5_CODE[0])); // R4
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(RATIO)); // R2
endmodule

// File: tb/sim_serial_tx_front.sv
`timescale 1ns/1ps
module sim_serial_tx_front;
  localparam int N = 10;
  localparam logic [9:0] K = 10'h17C;
  // fields: [20] en_hi, [19] en_lo_n, [18] special, [17:10] data, [9:0] expected code
  localparam logic [20:0] VEC [N] = '{
    {1'b1, 1'b1, 1'b0, 8'hA5, 10'h2A5},  // R2 R5 en_hi
    {1'b0, 1'b0, 1'b0, 8'h3C, 10'h23C},  // R2 R5 en_lo_n
    {1'b0, 1'b1, 1'b0, 8'hFF, 10'h17C},  // R4 idle
    {1'b1, 1'b0, 1'b0, 8'h00, 10'h200},  // R5 both enables
    {1'b1, 1'b1, 1'b1, 8'hBC, 10'h17C},  // R6 special K28.5
    {1'b0, 1'b0, 1'b1, 8'h1C, 10'h31C},  // R6 other special
    {1'b0, 1'b1, 1'b1, 8'h55, 10'h17C},  // R4 idle with special
    {1'b1, 1'b1, 1'b0, 8'h81, 10'h281},  // R5
    {1'b0, 1'b0, 1'b0, 8'hBC, 10'h2BC},  // R5 0xBC as data
    {1'b0, 1'b1, 1'b0, 8'h00, 10'h17C}   // R4
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] tx_data = 8'h00;
  logic tx_special = 1'b0;
  logic tx_en_hi = 1'b0;
  logic tx_en_lo_n = 1'b1;
  logic ser_out;
  logic rd_strobe_n;
  int checks = 0;
  int failures = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  serial_tx_front u0 (
    .clk(clk), .rst(rst), .tx_data(tx_data), .tx_special(tx_special),
    .tx_en_hi(tx_en_hi), .tx_en_lo_n(tx_en_lo_n),
    .ser_out(ser_out), .rd_strobe_n(rd_strobe_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // reset state, R1
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 strobe in reset", rd_strobe_n, 1'b1);
    chk("R1 line in reset", ser_out, K[0]);
    rst = 1'b0;

    // vector walk: R2 R3 R4 R5 R6 R7 R8 checked every cycle
    for (int p = 1; p <= 10 * (N + 2) + 9; p++) begin
      int v = (p + 9) / 10;
      logic [20:0] cur = (v >= 1 && v <= N) ? VEC[v-1] : {1'b0, 1'b1, 1'b0, 8'h00, K};
      tx_en_hi   = cur[20];
      tx_en_lo_n = cur[19];
      if (p % 10 == 0) begin
        tx_special = cur[18];
        tx_data    = cur[17:10];
      end else begin
        tx_special = p[0];               // R3 off-boundary noise
        tx_data    = 8'(p * 37) ^ 8'h5A;
      end
      @(posedge clk);
      @(negedge clk);
      begin
        int vo = p / 10 - 1;
        logic [9:0] code = (vo >= 1 && vo <= N) ? VEC[vo-1][9:0] : K;
        chk("R7 serial bit", ser_out, code[p % 10]);
        chk("R8 strobe", rd_strobe_n, !(cur[19] == 1'b0 && (p % 10) < 6));
      end
    end

    // mid-run reset, R1
    tx_en_hi = 1'b1; tx_en_lo_n = 1'b0; tx_data = 8'h81; tx_special = 1'b0;
    repeat (13) @(posedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1 strobe after reset", rd_strobe_n, 1'b1);
    chk("R1 line after reset", ser_out, K[0]);
    tx_en_hi = 1'b0; tx_en_lo_n = 1'b1;
    rst = 1'b0;
    for (int p = 1; p <= 19; p++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R1 fill after reset", ser_out, K[p % 10]);
      chk("R8 strobe idle", rd_strobe_n, 1'b1);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule